// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial port. Software picks the word length (7, 8 or 9 bits), whether a parity slot is sent and checked, odd or even parity, and one or two stop bits. A selector chooses where the oversampling tick comes from: a programmable divider inside the block, a tick pulse from an external timer, or the rising edges of an external clock pin. Every serial bit lasts 16 of these ticks.

The transmitter turns a loaded word into a frame and sends it least significant bit first. The slot after the data carries either a computed parity bit or, in 9-bit mode, the ninth data bit. The receiver validates a start bit at mid-bit, samples each later bit at its centre, and presents the word, the captured slot bit, a valid flag and three error flags. Each direction gives a one-cycle completion pulse to use as an interrupt. A gate on the serial data output holds the pin at the idle level when the output is turned off.

Top module: `sercom_uart`

## Requirements
- R1: After reset, sout is 1 and tx_busy, rx_valid, irq_tx, irq_rx, err_par, err_frame and err_ovr are all 0.
- R2: clk_sel picks the oversampling tick: 0 gives one tick every baud_div+1 clocks, 1 takes each high cycle of timer_tick as a tick, 2 takes each rising edge of ext_clk as a tick, and 3 gives no ticks, so any frame in progress stalls. One serial bit lasts 16 ticks.
- R3: A frame is one low start bit, then the data bits least significant first (7 bits when data_len is 0, 8 bits when data_len is 1 or 3, 8 bits plus a slot when data_len is 2), then an optional slot bit, then one high stop bit, or two when two_stop is 1. The line is high between frames.
- R4: When par_en is 1 and data_len is not 2, the slot is present and carries the XOR of the sent data bits XOR par_odd (par_odd 0 gives even parity over data and slot, 1 gives odd).
- R5: When data_len is 2 the slot is always present and carries tx_data[8]; the receiver stores that slot bit in rx_par and performs no parity check.
- R6: tx_start is taken only while tx_busy is 0; a tx_start during a frame has no effect on the frame. irq_tx is a one-cycle pulse asserted on the same clock edge at which tx_busy falls after the last stop bit.
- R7: While so_en is 0, sout stays 1 whatever the transmitter does.
- R8: A low level on sin starts reception only if it is still low when sampled 8 ticks later; a shorter low pulse is discarded with no word and no flag.
- R9: At the centre of the first stop bit the receiver loads rx_data and rx_par, sets rx_valid and pulses irq_rx for one cycle. In 7-bit mode rx_data[7] is 0; with no slot in the frame rx_par is 0.
- R10: err_par is set when a received frame with par_en 1 and data_len other than 2 has a slot bit that disagrees with the R4 rule.
- R11: err_frame is set when the first stop bit is sampled low; the receiver then waits for sin to return high before it looks for a new start bit.
- R12: err_ovr is set when a word completes while rx_valid is 1 and rx_read is not asserted in that cycle; the new word replaces the old one.
- R13: rx_read clears rx_valid and err_clr clears all three error flags; if a word completes in the same cycle, its new status wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_sel | input | 2 | Tick source select (0 divider, 1 timer, 2 external clock, 3 none) |
| baud_div | input | DIV_W | Divider terminal count; tick period is baud_div+1 clocks |
| timer_tick | input | 1 | Tick pulse from an external timer |
| ext_clk | input | 1 | External bit-rate clock, asynchronous |
| data_len | input | 2 | Word length: 0 is 7 bits, 1 or 3 is 8 bits, 2 is 9 bits |
| par_en | input | 1 | Adds the parity slot and enables the parity check |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| two_stop | input | 1 | Transmitter sends two stop bits |
| so_en | input | 1 | Enables the serial data output |
| tx_start | input | 1 | Load strobe for tx_data |
| tx_data | input | 9 | Word to send; bit 8 is used only in 9-bit mode |
| tx_busy | output | 1 | A frame is being sent |
| irq_tx | output | 1 | One-cycle pulse at the end of a frame |
| sout | output | 1 | Serial data output |
| sin | input | 1 | Serial data input, asynchronous |
| rx_data | output | 8 | Last received word |
| rx_par | output | 1 | Received parity or ninth bit |
| rx_valid | output | 1 | An unread word is held |
| rx_read | input | 1 | Marks the held word as read |
| err_par | output | 1 | Parity error flag |
| err_frame | output | 1 | Framing error flag |
| err_ovr | output | 1 | Overrun flag |
| err_clr | input | 1 | Clears the three error flags |
| irq_rx | output | 1 | One-cycle pulse when a word completes |

## Verification
A wrong bit counter or frame length shows at sout as a bit in the wrong slot or a stop bit arriving early, visible within one bit time of the slip, and as irq_tx firing too early or too late. A wrong sampling phase or slot index in the receiver shows as a wrong rx_data, rx_par or a spurious error flag at the next irq_rx, roughly half a bit after the frame's stop bit starts. A wrong tick source shows as bit times that do not match 16 ticks, which disturbs every sampled bit of the frame.

// File: rtl/sercom_pkg.sv
package sercom_pkg;

    localparam logic [1:0] SRC_DIV = 2'd0;
    localparam logic [1:0] SRC_TMR = 2'd1;
    localparam logic [1:0] SRC_EXT = 2'd2;

    localparam logic [1:0] LEN7 = 2'd0;
    localparam logic [1:0] LEN9 = 2'd2;

    localparam int OVS       = 16;
    localparam int PH_W      = $clog2(OVS);
    localparam int FRAME_W   = 12;
    localparam int CNT_W     = 4;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_BITS,
        RX_STOP,
        RX_BREAK
    } rx_st_e;

    function automatic logic [CNT_W-1:0] data_bits(input logic [1:0] len);
        return (len == LEN7) ? CNT_W'(7) : CNT_W'(8);
    endfunction

    function automatic logic slot_used(input logic [1:0] len, input logic par_en);
        return (len == LEN9) || par_en;
    endfunction

endpackage

// File: rtl/sercom_tick.sv
module sercom_tick
    import sercom_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       src,
    input  logic [DIV_W-1:0] div,
    input  logic             tmr_tick,
    input  logic             ext_clk,
    output logic             os_tick
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [2:0]       ext_sync;
        logic             tick;
    } tick_s_t;

    tick_s_t s_q, s_d;

    always_comb begin
        s_d          = s_q;
        s_d.ext_sync = {s_q.ext_sync[1:0], ext_clk};
        s_d.cnt      = (s_q.cnt >= div) ? '0 : s_q.cnt + 1'b1;
        unique case (src)
            SRC_DIV: s_d.tick = (s_q.cnt >= div);
            SRC_TMR: s_d.tick = tmr_tick;
            SRC_EXT: s_d.tick = s_q.ext_sync[1] & ~s_q.ext_sync[2];
            default: s_d.tick = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign os_tick = s_q.tick;

endmodule

// File: rtl/sercom_tx.sv
module sercom_tx
    import sercom_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       os_tick,
    input  logic       start,
    input  logic [8:0] data,
    input  logic [1:0] len,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       two_stop,
    output logic       line,
    output logic       busy,
    output logic       done
);

    typedef struct packed {
        logic               busy;
        logic [FRAME_W-1:0] frame;
        logic [CNT_W-1:0]   left;
        logic [PH_W-1:0]    ph;
        logic               done;
    } tx_s_t;

    tx_s_t s_q, s_d;

    logic [FRAME_W-1:0] fr;
    logic [CNT_W-1:0]   nd;
    logic [CNT_W-1:0]   flen;
    logic [7:0]         dm;
    logic               slot;
    logic               slot_bit;

    always_comb begin
        nd       = data_bits(len);
        slot     = slot_used(len, par_en);
        dm       = (len == LEN7) ? {1'b0, data[6:0]} : data[7:0];
        slot_bit = (len == LEN9) ? data[8] : (^dm ^ par_odd);
        fr       = '1;
        fr[0]    = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (i < int'(nd)) fr[i+1] = dm[i];
        end
        if (slot) fr[nd + CNT_W'(1)] = slot_bit;
        flen = CNT_W'(1) + nd + {{(CNT_W-1){1'b0}}, slot}
             + (two_stop ? CNT_W'(2) : CNT_W'(1));

        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.busy) begin
            if (start) begin
                s_d.busy  = 1'b1;
                s_d.frame = fr;
                s_d.left  = flen;
                s_d.ph    = '0;
            end
        end else if (os_tick) begin
            if (s_q.ph == PH_W'(OVS - 1)) begin
                s_d.ph    = '0;
                s_d.frame = {1'b1, s_q.frame[FRAME_W-1:1]};
                s_d.left  = s_q.left - 1'b1;
                if (s_q.left == CNT_W'(1)) begin
                    s_d.busy = 1'b0;
                    s_d.done = 1'b1;
                end
            end else begin
                s_d.ph = s_q.ph + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign line = s_q.busy ? s_q.frame[0] : 1'b1;
    assign busy = s_q.busy;
    assign done = s_q.done;

endmodule

// File: rtl/sercom_rx.sv
module sercom_rx
    import sercom_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       os_tick,
    input  logic       sin,
    input  logic [1:0] len,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       rd,
    input  logic       clr,
    output logic [7:0] data,
    output logic       pbit,
    output logic       valid,
    output logic       e_par,
    output logic       e_frm,
    output logic       e_ovr,
    output logic       done
);

    typedef struct packed {
        logic [1:0]       sync;
        rx_st_e           st;
        logic [PH_W-1:0]  ph;
        logic [CNT_W-1:0] idx;
        logic [8:0]       bits;
        logic [7:0]       data;
        logic             pbit;
        logic             valid;
        logic             e_par;
        logic             e_frm;
        logic             e_ovr;
        logic             done;
    } rx_s_t;

    rx_s_t s_q, s_d;

    logic             line;
    logic [CNT_W-1:0] nd;
    logic [CNT_W-1:0] nb;
    logic             slot;
    logic [7:0]       wd;
    logic             sb;

    always_comb begin
        line = s_q.sync[1];
        nd   = data_bits(len);
        slot = slot_used(len, par_en);
        nb   = nd + {{(CNT_W-1){1'b0}}, slot};
        wd   = (len == LEN7) ? {1'b0, s_q.bits[6:0]} : s_q.bits[7:0];
        sb   = slot ? s_q.bits[nd] : 1'b0;

        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.sync = {s_q.sync[0], sin};
        if (rd) s_d.valid = 1'b0;
        if (clr) begin
            s_d.e_par = 1'b0;
            s_d.e_frm = 1'b0;
            s_d.e_ovr = 1'b0;
        end

        if (os_tick) begin
            unique case (s_q.st)
                RX_IDLE: begin
                    if (!line) begin
                        s_d.st = RX_START;
                        s_d.ph = '0;
                    end
                end
                RX_START: begin
                    if (s_q.ph == PH_W'(OVS/2 - 1)) begin
                        s_d.ph  = '0;
                        s_d.idx = '0;
                        s_d.st  = line ? RX_IDLE : RX_BITS;
                    end else begin
                        s_d.ph = s_q.ph + 1'b1;
                    end
                end
                RX_BITS: begin
                    if (s_q.ph == PH_W'(OVS - 1)) begin
                        s_d.ph             = '0;
                        s_d.bits[s_q.idx]  = line;
                        s_d.idx            = s_q.idx + 1'b1;
                        if (s_q.idx == nb - 1'b1) s_d.st = RX_STOP;
                    end else begin
                        s_d.ph = s_q.ph + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (s_q.ph == PH_W'(OVS - 1)) begin
                        s_d.ph    = '0;
                        s_d.st    = line ? RX_IDLE : RX_BREAK;
                        s_d.data  = wd;
                        s_d.pbit  = sb;
                        s_d.done  = 1'b1;
                        s_d.valid = 1'b1;
                        if (s_q.valid && !rd) s_d.e_ovr = 1'b1;
                        if (!line) s_d.e_frm = 1'b1;
                        if (par_en && (len != LEN9) && ((^wd ^ sb) != par_odd))
                            s_d.e_par = 1'b1;
                    end else begin
                        s_d.ph = s_q.ph + 1'b1;
                    end
                end
                default: begin
                    if (line) s_d.st = RX_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.sync <= 2'b11;
        end else begin
            s_q <= s_d;
        end
    end

    assign data  = s_q.data;
    assign pbit  = s_q.pbit;
    assign valid = s_q.valid;
    assign e_par = s_q.e_par;
    assign e_frm = s_q.e_frm;
    assign e_ovr = s_q.e_ovr;
    assign done  = s_q.done;

endmodule

// File: rtl/sercom_uart.sv
module sercom_uart #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       clk_sel,
    input  logic [DIV_W-1:0] baud_div,
    input  logic             timer_tick,
    input  logic             ext_clk,
    input  logic [1:0]       data_len,
    input  logic             par_en,
    input  logic             par_odd,
    input  logic             two_stop,
    input  logic             so_en,
    input  logic             tx_start,
    input  logic [8:0]       tx_data,
    output logic             tx_busy,
    output logic             irq_tx,
    output logic             sout,
    input  logic             sin,
    output logic [7:0]       rx_data,
    output logic             rx_par,
    output logic             rx_valid,
    input  logic             rx_read,
    output logic             err_par,
    output logic             err_frame,
    output logic             err_ovr,
    input  logic             err_clr,
    output logic             irq_rx
);

    logic os_tick;
    logic tx_line;

    sercom_tick #(.DIV_W(DIV_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (clk_sel),
        .div      (baud_div),
        .tmr_tick (timer_tick),
        .ext_clk  (ext_clk),
        .os_tick  (os_tick)
    );

    sercom_tx u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .os_tick  (os_tick),
        .start    (tx_start),
        .data     (tx_data),
        .len      (data_len),
        .par_en   (par_en),
        .par_odd  (par_odd),
        .two_stop (two_stop),
        .line     (tx_line),
        .busy     (tx_busy),
        .done     (irq_tx)
    );

    sercom_rx u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .os_tick  (os_tick),
        .sin      (sin),
        .len      (data_len),
        .par_en   (par_en),
        .par_odd  (par_odd),
        .rd       (rx_read),
        .clr      (err_clr),
        .data     (rx_data),
        .pbit     (rx_par),
        .valid    (rx_valid),
        .e_par    (err_par),
        .e_frm    (err_frame),
        .e_ovr    (err_ovr),
        .done     (irq_rx)
    );

    assign sout = so_en ? tx_line : 1'b1;

endmodule

// File: rtl/sercom_uart_chk.sv
module sercom_uart_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] data_len,
    input logic       so_en,
    input logic       sout,
    input logic       tx_busy,
    input logic       irq_tx,
    input logic       irq_rx,
    input logic       rx_valid,
    input logic       rx_read,
    input logic [7:0] rx_data,
    input logic       err_par,
    input logic       err_frame,
    input logic       err_ovr,
    input logic       err_clr
);

    AST_LINE_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> sout);                                               // R3

    AST_OUTPUT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !so_en |-> sout);                                                 // R7

    AST_TX_END_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_busy) |-> irq_tx);                                       // R6

    AST_TX_PULSE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx |=> !irq_tx);                                              // R6

    AST_RX_DONE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx |-> rx_valid);                                             // R9

    AST_LEN7_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_rx && $past(data_len) == 2'd0) |-> !rx_data[7]);            // R9

    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_rx && $past(rx_valid) && !$past(rx_read)) |-> err_ovr);      // R12

    AST_FLAGS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(err_clr) && !irq_rx) |-> !(err_par || err_frame || err_ovr)); // R13

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rx_read) && !irq_rx) |-> !rx_valid);                       // R13

endmodule

bind sercom_uart sercom_uart_chk u_chk (.*);

// File: tb/sercom_uart_test.sv
`timescale 1ns/1ps
module sercom_uart_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] clk_sel = 2'd0;
    logic [11:0] baud_div = '0;
    logic       timer_tick;
    logic       ext_clk;
    logic [1:0] data_len = 2'd1;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       two_stop = 1'b0;
    logic       so_en = 1'b1;
    logic       tx_start = 1'b0;
    logic [8:0] tx_data = '0;
    logic       tx_busy;
    logic       irq_tx;
    logic       sout;
    logic       sin;
    logic [7:0] rx_data;
    logic       rx_par;
    logic       rx_valid;
    logic       rx_read = 1'b0;
    logic       err_par;
    logic       err_frame;
    logic       err_ovr;
    logic       err_clr = 1'b0;
    logic       irq_rx;

    logic       loop = 1'b1;
    logic       sin_drv = 1'b1;
    int         checks = 0;
    int         errors = 0;
    int         n_tx = 0;
    int         n_rx = 0;
    logic [1:0] tcnt = '0;
    logic [1:0] ecnt = '0;
    bit         done_flag = 0;

    always #10 clk = ~clk;

    assign sin        = loop ? sout : sin_drv;
    assign timer_tick = (tcnt == 2'd0);
    assign ext_clk    = ecnt[1];

    always @(negedge clk) begin
        tcnt <= (tcnt == 2'd2) ? 2'd0 : tcnt + 2'd1;
        ecnt <= ecnt + 2'd1;
        if (irq_tx) n_tx <= n_tx + 1;
        if (irq_rx) n_rx <= n_rx + 1;
    end

    sercom_uart #(.DIV_W(12)) uut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done_flag) begin
            done_flag = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic rd_clear();
        @(negedge clk); rx_read = 1'b1; err_clr = 1'b1;
        @(negedge clk); rx_read = 1'b0; err_clr = 1'b0;
    endtask

    // Transmit one word with loopback; check sout at bit centres and the received result.
    task automatic send(input logic [8:0] d, input int bp, input bit extra);
        logic [11:0] fr;
        logic [7:0]  dm;
        logic        pb;
        bit          slot;
        int          nd, n, pos, tgt, tx0, rx0, t;
        nd   = (data_len == 2'd0) ? 7 : 8;
        dm   = (data_len == 2'd0) ? {1'b0, d[6:0]} : d[7:0];
        slot = (data_len == 2'd2) || par_en;
        pb   = (data_len == 2'd2) ? d[8] : (^dm ^ par_odd);
        fr   = '1;
        fr[0] = 1'b0;
        for (int i = 0; i < nd; i++) fr[i+1] = dm[i];
        if (slot) fr[nd+1] = pb;
        n = 1 + nd + (slot ? 1 : 0) + (two_stop ? 2 : 1);
        tx0 = n_tx; rx0 = n_rx;
        @(negedge clk); tx_data = d; tx_start = 1'b1;
        @(negedge clk); tx_start = 1'b0;
        pos = 1;
        for (int i = 0; i < n; i++) begin
            tgt = bp * i + bp / 2;
            repeat (tgt - pos) @(negedge clk);
            pos = tgt;
            if (!so_en)
                chk(sout == 1'b1, "R7 gated output", sout, 1);
            else if (slot && i == nd + 1)
                chk(sout == fr[i], (data_len == 2'd2) ? "R5 ninth bit slot" : "R4 parity slot", sout, fr[i]);
            else
                chk(sout == fr[i], "R3 frame bit", sout, fr[i]);
            if (extra && i == 1) begin
                tx_data = ~d; tx_start = 1'b1;
                @(negedge clk); tx_start = 1'b0; tx_data = d;
                pos++;
            end
        end
        t = 0;
        while (tx_busy && t < 4 * bp) begin @(negedge clk); t++; end
        @(negedge clk);
        chk(n_tx == tx0 + 1, "R6 one irq_tx per frame", n_tx - tx0, 1);
        if (so_en && loop) begin
            chk(n_rx == rx0 + 1, "R9 one irq_rx per word", n_rx - rx0, 1);
            chk(rx_valid == 1'b1, "R9 rx_valid set", rx_valid, 1);
            chk(rx_data == dm, "R9 received word", rx_data, dm);
            chk(rx_par == (slot ? pb : 1'b0), "R5 received slot bit", rx_par, slot ? pb : 1'b0);
            chk(!err_par && !err_frame && !err_ovr, "R10 no error on clean frame",
                {err_par, err_frame, err_ovr}, 0);
        end else begin
            chk(n_rx == rx0, "R7 nothing received while gated", n_rx - rx0, 0);
        end
        @(negedge clk); rx_read = 1'b1;
        @(negedge clk); rx_read = 1'b0;
        chk(rx_valid == 1'b0, "R13 rx_read clears rx_valid", rx_valid, 0);
    endtask

    // Drive raw bits onto sin, 16 clocks each (divider 0), then idle high.
    task automatic drive(input logic [11:0] bits, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sin_drv = bits[i];
            repeat (15) @(negedge clk);
        end
        @(negedge clk); sin_drv = 1'b1;
        repeat (24) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
    end

    initial begin
        int rx0, t;
        repeat (3) @(negedge clk);
        chk(sout == 1'b1 && tx_busy == 1'b0, "R1 reset tx side", {sout, tx_busy}, 2'b10);
        chk(!rx_valid && !irq_rx && !irq_tx, "R1 reset rx side", {rx_valid, irq_rx, irq_tx}, 0);
        chk(!err_par && !err_frame && !err_ovr, "R1 reset flags", {err_par, err_frame, err_ovr}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(sout == 1'b1 && !tx_busy && !rx_valid, "R1 idle after reset", {sout, tx_busy, rx_valid}, 3'b100);

        // Sweep every frame configuration with several words
        for (int l = 0; l < 3; l++)
            for (int p = 0; p < 2; p++)
                for (int o = 0; o < 2; o++)
                    for (int s = 0; s < 2; s++) begin
                        data_len = 2'(l); par_en = p[0]; par_odd = o[0]; two_stop = s[0];
                        send(9'h000, 16, 0);
                        send(9'h1FF, 16, 0);
                        send(9'h0A5, 16, 0);
                        send(9'h15A, 16, 0);
                        send(9'((l * 8 + p * 4 + o * 2 + s) * 37 + 11), 16, 0);
                    end

        // R6: tx_start during a frame is ignored
        data_len = 2'd1; par_en = 1'b1; par_odd = 1'b1; two_stop = 1'b0;
        send(9'h03C, 16, 1);

        // R7: gated output
        so_en = 1'b0;
        send(9'h000, 16, 0);
        so_en = 1'b1;

        // R2: tick sources
        par_en = 1'b0;
        clk_sel = 2'd0; baud_div = 12'd2;
        send(9'h0A5, 48, 0);
        clk_sel = 2'd1;
        send(9'h05A, 48, 0);
        clk_sel = 2'd2;
        send(9'h0C3, 64, 0);
        clk_sel = 2'd3;
        @(negedge clk); tx_data = 9'h0FF; tx_start = 1'b1;
        @(negedge clk); tx_start = 1'b0;
        repeat (100) @(negedge clk);
        chk(tx_busy == 1'b1 && sout == 1'b0, "R2 no ticks stalls frame", {tx_busy, sout}, 2'b10);
        clk_sel = 2'd0; baud_div = 12'd0;
        t = 0;
        while (tx_busy && t < 400) begin @(negedge clk); t++; end
        chk(tx_busy == 1'b0, "R2 frame resumes with ticks", tx_busy, 0);
        repeat (20) @(negedge clk);
        rd_clear();

        // Direct stimulus on sin
        loop = 1'b0;
        data_len = 2'd1; par_en = 1'b1; par_odd = 1'b0; two_stop = 1'b0;
        // data 0x01, even parity should be 1; send 0
        drive(12'h402, 11);
        chk(err_par == 1'b1, "R10 parity error flagged", err_par, 1);
        chk(err_frame == 1'b0 && rx_data == 8'h01, "R10 word kept", {err_frame, rx_data}, 9'h001);
        chk(rx_par == 1'b0, "R9 received parity bit", rx_par, 0);
        rd_clear();
        chk(!err_par && !err_frame && !err_ovr && !rx_valid, "R13 clear strobes",
            {err_par, err_frame, err_ovr, rx_valid}, 0);

        par_en = 1'b0;
        // data 0x55 with a low stop bit
        drive(12'h0AA, 10);
        chk(err_frame == 1'b1, "R11 framing error flagged", err_frame, 1);
        chk(rx_data == 8'h55, "R11 word captured", rx_data, 8'h55);
        rx0 = n_rx;
        repeat (40) @(negedge clk);
        chk(n_rx == rx0, "R11 no false frame after break", n_rx - rx0, 0);
        rd_clear();

        // Overrun: two words without a read
        rx0 = n_rx;
        drive(12'h222, 10);
        drive(12'h244, 10);
        chk(n_rx == rx0 + 2, "R12 two words completed", n_rx - rx0, 2);
        chk(err_ovr == 1'b1, "R12 overrun flagged", err_ovr, 1);
        chk(rx_data == 8'h22, "R12 newer word kept", rx_data, 8'h22);
        rd_clear();

        // Short low glitch
        rx0 = n_rx;
        @(negedge clk); sin_drv = 1'b0;
        repeat (4) @(negedge clk); sin_drv = 1'b1;
        repeat (300) @(negedge clk);
        chk(n_rx == rx0 && !rx_valid, "R8 glitch discarded", n_rx - rx0, 0);
        chk(!err_par && !err_frame && !err_ovr, "R8 no flag on glitch",
            {err_par, err_frame, err_ovr}, 0);

        summary();
    end

endmodule